// File: doc/BRIEF.md
# Mains-Cycle Window Accumulator with Shadow Latch

This block sits behind the sampling and filtering stages of a metering datapath. Each qualified pair of signed voltage and current samples adds three terms to running sums: voltage squared, current squared and the signed product of voltage and current. A window is a whole number of line cycles, and the block finds the cycle boundaries itself from rising zero crossings of the voltage stream. When a window closes, the three sums, the number of samples in the window and a degraded marker are copied together into shadow outputs, and a data-ready flag goes high. Downstream RMS, power and power-factor logic reads these outputs.

The block also measures the length of each line cycle in samples. A cycle counts as healthy only if that length lies between two programmed bounds, which are normally set to about 45 Hz and 65 Hz at the sample rate in use. Without a healthy line the block still produces results. It closes windows after a fixed number of samples and marks each of them degraded. A consumer acknowledges each result with a strobe. A result that completes while the previous one is still unacknowledged raises an overrun flag.

Top module: `line_window_acc`

## Requirements
- R1: A crossing occurs on a valid sample whose voltage is greater than +DB (parameter DB) when at least one valid sample below -DB has been seen since the previous crossing. Values inside the band from -DB to +DB never arm or fire a crossing.
- R2: `line_ok` is 0 after reset. At each crossing after the first, it becomes 1 if the cycle length lies in [`per_min`, `per_max`] and 0 otherwise. The cycle length is the number of valid samples from the previous crossing sample, counted inclusive, up to the current crossing sample, not counted. `line_ok` is also cleared when the count since the last crossing grows past `per_max`.
- R3: `win_sel` encodes the cycles per window as 0 = 1 cycle, 1 = 4 cycles, 2 or 3 = 8 cycles. While `line_ok` is 1, a window closes on the crossing that is the Nth one since the window opened. That crossing sample is the first sample of the next window.
- R4: While `line_ok` is 0, a window that already holds FB_LEN valid samples closes on the next valid sample, which opens the next window. `shd_deg` reads 1 for windows closed this way and 0 for windows closed by a crossing.
- R5: At closing, `shd_vv`, `shd_ii`, `shd_vi` and `shd_cnt` hold the sum of v*v, the sum of i*i, the signed sum of v*i (two's complement) and the sample count, all taken over the samples of the closed window.
- R6: The shadow outputs change only in the cycle after a window closes and hold their values at all other times.
- R7: `rdy` rises in the cycle after every window close.
- R8: `ovf` is set when a window closes while `rdy` is 1 and `ack` is low in that cycle.
- R9: `ack` clears `rdy` and `ovf` in the next cycle, unless a window closes in the same cycle. In that case `rdy` stays 1 and `ovf` is cleared.
- R10: After reset all flags, `line_ok` and all shadow outputs are zero.
- R11: Samples with `smp_vld` low change no sum, no count and no crossing state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_vld | input | 1 | Sample qualifier |
| smp_v | input | SW | Signed voltage sample |
| smp_i | input | SW | Signed current sample |
| win_sel | input | 2 | Cycles per window code |
| per_min | input | CNTW | Shortest healthy cycle, in samples |
| per_max | input | CNTW | Longest healthy cycle, in samples |
| ack | input | 1 | Result acknowledge strobe |
| rdy | output | 1 | New result available |
| ovf | output | 1 | Result completed before the previous one was acknowledged |
| line_ok | output | 1 | Line frequency within the programmed band |
| shd_vv | output | ACCW | Latched sum of v squared |
| shd_ii | output | ACCW | Latched sum of i squared |
| shd_vi | output | ACCW | Latched signed sum of v times i |
| shd_cnt | output | CNTW | Latched sample count |
| shd_deg | output | 1 | Latched degraded marker |

## Verification
The bench builds the block with FB_LEN = 20, DB = 8 and 16-bit samples, and programs the cycle bounds to 12 and 24 samples. This setup lets square-wave cycles of 8 to 40 samples cross both bounds exactly, including periods 11, 12, 24, 25 and 40. A fallback window also fits within a handful of noise samples, so the bench can move between locked and degraded windows many times within one run. Every window code, overrun with a late acknowledge, dead-band-only waveforms and randomly interleaved invalid samples are all reached with short stimulus.

// File: rtl/linewin_pkg.sv
package linewin_pkg;

  typedef enum logic [1:0] {
    WSEL_1CYC = 2'd0,
    WSEL_4CYC = 2'd1,
    WSEL_8CYC = 2'd2,
    WSEL_8ALT = 2'd3
  } win_sel_e;

  // Number of line cycles that make up one window for a selector code.
  function automatic logic [3:0] cycles_of(input logic [1:0] sel);
    logic [3:0] n;
    case (win_sel_e'(sel))
      WSEL_1CYC: n = 4'd1;
      WSEL_4CYC: n = 4'd4;
      default:   n = 4'd8;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/linewin_zc.sv
// Rising zero-crossing detector with dead band and cycle-length check.
module linewin_zc #(
  parameter int SW   = 16,
  parameter int CNTW = 16,
  parameter int DB   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vld,
  input  logic signed [SW-1:0] v,
  input  logic [CNTW-1:0]      per_min,
  input  logic [CNTW-1:0]      per_max,
  output logic                 zc,
  output logic                 line_ok
);

  localparam logic signed [SW-1:0] DB_HI = SW'(DB);
  localparam logic signed [SW-1:0] DB_LO = -DB_HI;
  localparam logic [CNTW-1:0]      ONE   = CNTW'(1);
  localparam logic [CNTW-1:0]      TOP   = '1;

  logic            neg_q, neg_n;
  logic            have_q, have_n;
  logic            ok_q, ok_n;
  logic [CNTW-1:0] pcnt_q, pcnt_n, pcnt_inc;

  always_comb begin
    zc       = vld && neg_q && (v > DB_HI);
    pcnt_inc = (pcnt_q == TOP) ? pcnt_q : pcnt_q + ONE;
    neg_n    = neg_q;
    have_n   = have_q;
    ok_n     = ok_q;
    pcnt_n   = pcnt_q;
    if (vld) begin
      if (zc) begin
        neg_n  = 1'b0;
        have_n = 1'b1;
        pcnt_n = ONE;
        if (have_q) ok_n = (pcnt_q >= per_min) && (pcnt_q <= per_max);
      end else begin
        if (v < DB_LO) neg_n = 1'b1;
        pcnt_n = pcnt_inc;
        if (pcnt_inc > per_max) ok_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q  <= 1'b0;
      have_q <= 1'b0;
      ok_q   <= 1'b0;
      pcnt_q <= '0;
    end else if (vld) begin
      neg_q  <= neg_n;
      have_q <= have_n;
      ok_q   <= ok_n;
      pcnt_q <= pcnt_n;
    end
  end

  assign line_ok = ok_q;

  AST_LINE_OK_RISES_ON_CROSSING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_q) |-> $past(zc)); // R2

endmodule

// File: rtl/linewin_seq.sv
// Window sequencer: locked to crossings or fixed-length fallback.
module linewin_seq #(
  parameter int CNTW   = 16,
  parameter int FB_LEN = 800
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vld,
  input  logic            zc,
  input  logic            line_ok,
  input  logic [1:0]      win_sel,
  output logic            wend,
  output logic [CNTW-1:0] wcnt
);

  localparam logic [CNTW-1:0] FB_C = CNTW'(FB_LEN);
  localparam logic [CNTW-1:0] ONE  = CNTW'(1);
  localparam logic [CNTW-1:0] TOP  = '1;
  localparam logic [3:0]      CYC_CAP = 4'd14;

  logic [3:0]      ncyc;
  logic [3:0]      cyc_q, cyc_n;
  logic [CNTW-1:0] wcnt_q, wcnt_n;

  always_comb begin
    ncyc = linewin_pkg::cycles_of(win_sel);
    if (line_ok) wend = vld && zc && (({1'b0, cyc_q} + 5'd1) >= {1'b0, ncyc});
    else         wend = vld && (wcnt_q >= FB_C);
    cyc_n  = cyc_q;
    wcnt_n = wcnt_q;
    if (vld) begin
      if (wend) begin
        cyc_n  = 4'd0;
        wcnt_n = ONE;
      end else begin
        if (zc && (cyc_q < CYC_CAP)) cyc_n = cyc_q + 4'd1;
        wcnt_n = (wcnt_q == TOP) ? wcnt_q : wcnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      wcnt_q <= '0;
    end else if (vld) begin
      cyc_q  <= cyc_n;
      wcnt_q <= wcnt_n;
    end
  end

  assign wcnt = wcnt_q;

  AST_WINDOW_OPENS_WITH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    wend |=> (wcnt_q == ONE)); // R5

endmodule

// File: rtl/linewin_sums.sv
// Three product lanes: v*v, i*i, v*i, each cleared-and-loaded at window end.
module linewin_sums #(
  parameter int SW   = 16,
  parameter int ACCW = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vld,
  input  logic                 wend,
  input  logic signed [SW-1:0] v,
  input  logic signed [SW-1:0] i,
  output logic [ACCW-1:0]      sum_vv,
  output logic [ACCW-1:0]      sum_ii,
  output logic [ACCW-1:0]      sum_vi
);

  localparam int PW    = 2 * SW;
  localparam int LANES = 3;

  logic [ACCW-1:0] sum_q [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [SW-1:0] op_a, op_b;
    logic signed [PW-1:0] prod;
    logic [ACCW-1:0]      term, sum_n;

    always_comb begin
      op_a  = (g == 1) ? i : v;
      op_b  = (g == 0) ? v : i;
      prod  = op_a * op_b;
      term  = {{(ACCW-PW){prod[PW-1]}}, prod};
      sum_n = wend ? term : sum_q[g] + term;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sum_q[g] <= '0;
      else if (vld) sum_q[g] <= sum_n;
    end
  end

  assign sum_vv = sum_q[0];
  assign sum_ii = sum_q[1];
  assign sum_vi = sum_q[2];

endmodule

// File: rtl/line_window_acc.sv
module line_window_acc #(
  parameter int SW     = 16,
  parameter int ACCW   = 48,
  parameter int CNTW   = 16,
  parameter int DB     = 8,
  parameter int FB_LEN = 800
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic signed [SW-1:0] smp_v,
  input  logic signed [SW-1:0] smp_i,
  input  logic [1:0]           win_sel,
  input  logic [CNTW-1:0]      per_min,
  input  logic [CNTW-1:0]      per_max,
  input  logic                 ack,
  output logic                 rdy,
  output logic                 ovf,
  output logic                 line_ok,
  output logic [ACCW-1:0]      shd_vv,
  output logic [ACCW-1:0]      shd_ii,
  output logic [ACCW-1:0]      shd_vi,
  output logic [CNTW-1:0]      shd_cnt,
  output logic                 shd_deg
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rsync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  logic            zc, ok, wend;
  logic [CNTW-1:0] wcnt;
  logic [ACCW-1:0] sum_vv, sum_ii, sum_vi;

  linewin_zc #(.SW(SW), .CNTW(CNTW), .DB(DB)) u_zc (
    .clk(clk), .rst_n(rst_sn), .vld(smp_vld), .v(smp_v),
    .per_min(per_min), .per_max(per_max), .zc(zc), .line_ok(ok)
  );

  linewin_seq #(.CNTW(CNTW), .FB_LEN(FB_LEN)) u_seq (
    .clk(clk), .rst_n(rst_sn), .vld(smp_vld), .zc(zc), .line_ok(ok),
    .win_sel(win_sel), .wend(wend), .wcnt(wcnt)
  );

  linewin_sums #(.SW(SW), .ACCW(ACCW)) u_sums (
    .clk(clk), .rst_n(rst_sn), .vld(smp_vld), .wend(wend),
    .v(smp_v), .i(smp_i), .sum_vv(sum_vv), .sum_ii(sum_ii), .sum_vi(sum_vi)
  );

  // Shadow bank and result flags
  logic            rdy_q, rdy_n, ovf_q, ovf_n;
  logic [ACCW-1:0] svv_q, sii_q, svi_q;
  logic [CNTW-1:0] scnt_q;
  logic            sdeg_q;

  always_comb begin
    rdy_n = wend ? 1'b1 : (ack ? 1'b0 : rdy_q);
    ovf_n = (wend && rdy_q && !ack) ? 1'b1 : (ack ? 1'b0 : ovf_q);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rdy_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      rdy_q <= rdy_n;
      ovf_q <= ovf_n;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      svv_q  <= '0;
      sii_q  <= '0;
      svi_q  <= '0;
      scnt_q <= '0;
      sdeg_q <= 1'b0;
    end else if (wend) begin
      svv_q  <= sum_vv;
      sii_q  <= sum_ii;
      svi_q  <= sum_vi;
      scnt_q <= wcnt;
      sdeg_q <= !ok;
    end
  end

  assign rdy     = rdy_q;
  assign ovf     = ovf_q;
  assign line_ok = ok;
  assign shd_vv  = svv_q;
  assign shd_ii  = sii_q;
  assign shd_vi  = svi_q;
  assign shd_cnt = scnt_q;
  assign shd_deg = sdeg_q;

  AST_RDY_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_sn)
    wend |=> rdy); // R7
  AST_OVF_ON_MISSED: assert property (@(posedge clk) disable iff (!rst_sn)
    (wend && rdy && !ack) |=> ovf); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_sn)
    (ack && !wend) |=> (!rdy && !ovf)); // R9
  AST_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_sn)
    !wend |=> ($stable(shd_vv) && $stable(shd_ii) && $stable(shd_vi)
               && $stable(shd_cnt) && $stable(shd_deg))); // R6
  AST_RESULT_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_sn)
    rdy |-> (shd_cnt != '0)); // R5

endmodule

// File: tb/line_window_acc_tb_top.sv
module line_window_acc_tb_top;

  localparam int SW = 16, ACCW = 48, CNTW = 16, DB = 8, FB = 20;
  localparam int PMIN = 12, PMAX = 24;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 smp_vld;
  logic signed [SW-1:0] smp_v, smp_i;
  logic [1:0]           win_sel;
  logic [CNTW-1:0]      per_min, per_max;
  logic                 ack;
  logic                 rdy, ovf, line_ok, shd_deg;
  logic [ACCW-1:0]      shd_vv, shd_ii, shd_vi;
  logic [CNTW-1:0]      shd_cnt;

  always #2.5 clk = ~clk;

  line_window_acc #(.SW(SW), .ACCW(ACCW), .CNTW(CNTW), .DB(DB), .FB_LEN(FB)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_v(smp_v), .smp_i(smp_i),
    .win_sel(win_sel), .per_min(per_min), .per_max(per_max), .ack(ack),
    .rdy(rdy), .ovf(ovf), .line_ok(line_ok), .shd_vv(shd_vv), .shd_ii(shd_ii),
    .shd_vi(shd_vi), .shd_cnt(shd_cnt), .shd_deg(shd_deg)
  );

  int n_chk = 0, n_fail = 0;

  // Reference model state
  bit     m_neg, m_have, m_ok, m_rdy, m_ovf, m_deg;
  int     m_pcnt, m_cyc, m_wcnt, m_cnt;
  longint m_svv, m_sii, m_svi, m_hvv, m_hii, m_hvi;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int ncyc_of(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 4 : 8;
  endfunction

  task automatic model(input bit vld, input logic signed [SW-1:0] v,
                       input logic signed [SW-1:0] i, input bit a);
    bit zc, close;
    longint tvv, tii, tvi;
    zc = 0; close = 0;
    if (vld) begin
      zc  = m_neg && (v > DB);
      tvv = longint'(v) * longint'(v);
      tii = longint'(i) * longint'(i);
      tvi = longint'(v) * longint'(i);
      close = m_ok ? (zc && (m_cyc + 1 >= ncyc_of(win_sel))) : (m_wcnt >= FB);
      if (close) begin
        m_hvv = m_svv; m_hii = m_sii; m_hvi = m_svi;
        m_cnt = m_wcnt; m_deg = !m_ok;
        m_svv = tvv; m_sii = tii; m_svi = tvi;
        m_wcnt = 1; m_cyc = 0;
      end else begin
        m_svv += tvv; m_sii += tii; m_svi += tvi;
        m_wcnt++;
        if (zc && m_cyc < 14) m_cyc++;
      end
      if (zc) begin
        m_neg = 0;
        if (m_have) m_ok = (m_pcnt >= PMIN) && (m_pcnt <= PMAX);
        m_have = 1; m_pcnt = 1;
      end else begin
        if (v < -DB) m_neg = 1;
        m_pcnt++;
        if (m_pcnt > PMAX) m_ok = 0;
      end
    end
    if (close && m_rdy && !a) m_ovf = 1; else if (a) m_ovf = 0;
    if (close) m_rdy = 1; else if (a) m_rdy = 0;
  endtask

  task automatic compare_all();
    chk("R2", "line_ok", line_ok, m_ok);
    chk("R7", "rdy", rdy, m_rdy);
    chk("R8", "ovf", ovf, m_ovf);
    chk("R4", "shd_deg", shd_deg, m_deg);
    chk("R5", "shd_cnt", shd_cnt, m_cnt);
    chk("R5", "shd_vv", longint'(shd_vv), m_hvv);
    chk("R5", "shd_ii", longint'(shd_ii), m_hii);
    chk("R5", "shd_vi", longint'($signed(shd_vi)), m_hvi);
  endtask

  // One cycle: drive at the falling edge, compare at the next falling edge.
  task automatic step(input bit vld, input logic signed [SW-1:0] v,
                      input logic signed [SW-1:0] i, input bit a);
    smp_vld = vld; smp_v = v; smp_i = i; ack = a;
    model(vld, v, i, a);
    @(negedge clk);
    smp_vld = 1'b0; ack = 1'b0;
    compare_all();
  endtask

  function automatic logic signed [SW-1:0] rnd16();
    return SW'($urandom_range(0, 65535));
  endfunction

  function automatic bit ack_dec(input int pct);
    return m_rdy && ($urandom_range(0, 99) < pct);
  endfunction

  // Square-ish waveform of a given period in valid samples; R11 via gaps.
  task automatic wave(input int period, input int ncyc, input int amp_max,
                      input int gap_pct, input int ack_pct);
    for (int c = 0; c < ncyc; c++) begin
      for (int k = 0; k < period; k++) begin
        logic signed [SW-1:0] v;
        int amp;
        while ($urandom_range(0, 99) < gap_pct) step(1'b0, rnd16(), rnd16(), ack_dec(ack_pct));
        amp = (amp_max <= DB) ? amp_max : $urandom_range(DB + 1, amp_max);
        v = (k < period / 2) ? SW'(amp) : -SW'(amp);
        step(1'b1, v, rnd16(), ack_dec(ack_pct));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1 to all: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; smp_vld = 1'b0; smp_v = '0; smp_i = '0; ack = 1'b0;
    win_sel = 2'd0; per_min = CNTW'(PMIN); per_max = CNTW'(PMAX);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10: everything zero after reset
    chk("R10", "rdy", rdy, 0);
    chk("R10", "ovf", ovf, 0);
    chk("R10", "line_ok", line_ok, 0);
    chk("R10", "shd_cnt", shd_cnt, 0);
    chk("R10", "shd_vv", longint'(shd_vv), 0);
    chk("R10", "shd_deg", shd_deg, 0);

    // R1, R4, R11: dead-band noise only -> fallback windows, degraded
    for (int n = 0; n < 60; n++) begin
      if ($urandom_range(0, 99) < 30) step(1'b0, rnd16(), rnd16(), ack_dec(50));
      else step(1'b1, SW'($urandom_range(0, 2 * DB)) - SW'(DB), rnd16(), ack_dec(50));
    end
    chk("R4", "degraded after noise", shd_deg, 1);
    chk("R1", "no line from noise", line_ok, 0);

    // R3: locked windows for every selector code
    for (int s = 0; s < 4; s++) begin
      win_sel = 2'(s);
      wave(16, 18, 30000, 15, 60);
      chk("R2", "line_ok at 16-sample cycles", line_ok, 1);
    end

    // R8 then R9: overrun, then acknowledge
    win_sel = 2'd0;
    wave(16, 4, 30000, 0, 0);
    chk("R8", "overrun raised", ovf, 1);
    step(1'b0, '0, '0, 1'b1);
    chk("R9", "rdy cleared", rdy, 0);
    chk("R9", "ovf cleared", ovf, 0);

    // R2: band edges and out-of-band periods
    wave(12, 4, 30000, 10, 50);
    chk("R2", "period 12 in band", line_ok, 1);
    wave(24, 4, 30000, 10, 50);
    chk("R2", "period 24 in band", line_ok, 1);
    wave(11, 3, 30000, 10, 50);
    chk("R2", "period 11 out of band", line_ok, 0);
    wave(16, 3, 30000, 10, 50);
    wave(40, 3, 30000, 10, 50);
    chk("R2", "period 40 loses line", line_ok, 0);

    // R1: dead-band amplitude gives no crossings even at a normal period
    wave(16, 3, 30000, 0, 50);
    wave(16, 4, DB, 0, 50);
    chk("R1", "dead band wave drops line", line_ok, 0);

    // Random mix
    for (int b = 0; b < 25; b++) begin
      win_sel = 2'($urandom_range(0, 3));
      wave($urandom_range(8, 40), $urandom_range(2, 9), 32000,
           $urandom_range(0, 40), $urandom_range(20, 90));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule